// File: doc/BRIEF.md
# Smart Card Slot Power-Up Sequencer

This block brings a card slot from empty to ready and back. A presence pin, passed through a two-stage synchronizer and an optional inversion, starts a settling delay measured in system-clock cycles. When the delay ends, the block drives the active-low supply enable and enables the card clock in the same cycle. The data line direction stays at receive. The active-low card reset is held low until a fixed number of card-clock periods have gone by. Each period is signalled by a one-cycle tick from the clock divider. The reset is then released and a ready flag goes high.

When the card is pulled out in any phase, the block shuts the slot down in a fixed order. Reset goes low first, the clock stops one cycle later, and supply goes off one cycle after that. Steps that are already in their off state are skipped. The block then waits in idle for the next insertion. Decoding the card's answer to reset is left to the downstream receiver.

Top module: `card_power_seq`

## Requirements
- R1: The card counts as present when `card_detect` equals 1 with `detect_invert` at 0, or when `card_detect` equals 0 with `detect_invert` at 1; the opposite level counts as absent and never powers the slot.
- R2: With presence held, `pwr_en_n` goes low exactly SETTLE_CYCLES+3 system-clock cycles after the presence pin changes (two synchronizer stages, one entry cycle, SETTLE_CYCLES of delay).
- R3: `card_clk_en` goes to 1 in the same cycle that `pwr_en_n` goes to 0, and is never 1 while `pwr_en_n` is 1.
- R4: `io_rx` stays at 1 (receive) in every state.
- R5: `card_rst_n` stays 0 after power-up until RST_CLOCKS (default 512) `clk_tick` pulses have been sampled with power on, and goes to 1 on the clock edge that samples the last of them.
- R6: `ready` is 1 exactly while `card_rst_n` is 1.
- R7: On removal from the ready state, `card_rst_n` falls 3 cycles after the pin change, `card_clk_en` falls one cycle later, and `pwr_en_n` rises one cycle after that.
- R8: On removal while reset is still low, the clock stops 3 cycles after the pin change and power goes off one cycle later. On removal during the settling delay, power is never applied.
- R9: After `rst_n` is released and before any insertion, `pwr_en_n`=1, `card_clk_en`=0, `card_rst_n`=0, `ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| card_detect | input | 1 | Raw card presence pin (asynchronous) |
| detect_invert | input | 1 | 1 inverts the presence pin sense |
| clk_tick | input | 1 | One-cycle pulse per card-clock period |
| pwr_en_n | output | 1 | Active-low slot supply enable |
| card_clk_en | output | 1 | Card clock running |
| card_rst_n | output | 1 | Active-low card reset |
| io_rx | output | 1 | Data line direction, 1 = receive |
| ready | output | 1 | Card reset released, slot ready |

## Verification
The full insert-and-remove cycle is run under both presence polarities and with tick spacings of one, two and three system cycles. This separates a reset counter that counts system cycles from one that counts card-clock ticks. Polarity errors show up as a slot that powers on while empty. Removal is also tried during the settling delay and while reset is still low. These cases tell apart a shutdown that skips steps correctly from one that replays the full ordered sequence or applies power late.

// File: rtl/card_power_seq.sv
module card_power_seq #(
  parameter int SETTLE_CYCLES = 500000,
  parameter int RST_CLOCKS    = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic card_detect,
  input  logic detect_invert,
  input  logic clk_tick,
  output logic pwr_en_n,
  output logic card_clk_en,
  output logic card_rst_n,
  output logic io_rx,
  output logic ready
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam int RW = $clog2(RST_CLOCKS + 1);
  localparam logic [SW-1:0] S_LAST = SW'(SETTLE_CYCLES - 1);
  localparam logic [RW-1:0] R_LAST = RW'(RST_CLOCKS - 1);

  typedef enum logic [2:0] {IDLE, SETTLE, POWERED, ACTIVE, DROP_RST, STOP_CLK} st_t;

  st_t           st;
  logic [1:0]    sync;
  logic [SW-1:0] scnt;
  logic [RW-1:0] rcnt;
  logic          present;

  assign present = sync[1] ^ detect_invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b00;
      st   <= IDLE;
      scnt <= '0;
      rcnt <= '0;
    end else begin
      sync <= {sync[0], card_detect};
      unique case (st)
        IDLE: if (present) begin
          st   <= SETTLE;
          scnt <= '0;
        end
        SETTLE:
          if (!present) st <= IDLE;
          else if (scnt == S_LAST) begin
            st   <= POWERED;
            rcnt <= '0;
          end else scnt <= scnt + 1'b1;
        POWERED:
          if (!present) st <= STOP_CLK;
          else if (clk_tick) begin
            if (rcnt == R_LAST) st <= ACTIVE;
            else rcnt <= rcnt + 1'b1;
          end
        ACTIVE:   if (!present) st <= DROP_RST;
        DROP_RST: st <= STOP_CLK;
        STOP_CLK: st <= IDLE;
        default:  st <= IDLE;
      endcase
    end
  end

  assign pwr_en_n    = (st == IDLE) || (st == SETTLE);
  assign card_clk_en = (st == POWERED) || (st == ACTIVE) || (st == DROP_RST);
  assign card_rst_n  = (st == ACTIVE);
  assign ready       = (st == ACTIVE);
  assign io_rx       = 1'b1;
endmodule

// File: rtl/card_power_seq_chk.sv
module card_power_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_en_n,
  input logic card_clk_en,
  input logic card_rst_n,
  input logic ready
);
  // R3
  clk_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_clk_en |-> !pwr_en_n);
  // R3
  clk_with_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en_n) |-> $rose(card_clk_en));
  // R6
  ready_tracks_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready == card_rst_n);
  // R5
  reset_release_clocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst_n |-> card_clk_en);
  // R7
  clk_stop_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_clk_en) |-> (!card_rst_n && $past(!card_rst_n)));
  // R7
  power_off_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en_n) |-> $past(!card_clk_en));
endmodule

bind card_power_seq card_power_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_en_n(pwr_en_n), .card_clk_en(card_clk_en),
  .card_rst_n(card_rst_n), .ready(ready)
);

// File: tb/tb_card_power_seq.sv
`timescale 1ns/1ps
module tb_card_power_seq;
  localparam int SETTLE  = 20;
  localparam int RSTCLK  = 512;
  localparam int EXP_PWR = SETTLE + 3;
  // {polarity, tick period}
  localparam logic [3:0] VEC [4] = '{4'b0_001, 4'b1_001, 4'b0_011, 4'b1_010};

  logic clk = 0, rst_n = 0, card_detect = 0, detect_invert = 0, clk_tick = 0;
  logic pwr_en_n, card_clk_en, card_rst_n, io_rx, ready;

  int n_chk = 0, n_fail = 0, cycles = 0;
  int tick_per = 1, tphase = 0, ticks_seen = 0;

  card_power_seq #(.SETTLE_CYCLES(SETTLE), .RST_CLOCKS(RSTCLK)) dut (
    .clk(clk), .rst_n(rst_n), .card_detect(card_detect), .detect_invert(detect_invert),
    .clk_tick(clk_tick), .pwr_en_n(pwr_en_n), .card_clk_en(card_clk_en),
    .card_rst_n(card_rst_n), .io_rx(io_rx), .ready(ready));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (tphase >= tick_per - 1) begin tphase = 0; clk_tick = 1; end
    else begin tphase++; clk_tick = 0; end
    if (clk_tick && !pwr_en_n && !card_rst_n) ticks_seen++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic idle_outputs(input string req);
    chk({req, " pwr_en_n"}, pwr_en_n, 1);
    chk({req, " card_clk_en"}, card_clk_en, 0);
    chk({req, " card_rst_n"}, card_rst_n, 0);
    chk({req, " ready"}, ready, 0);
  endtask

  task automatic wait_power(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (pwr_en_n && k < 1000);
  endtask

  initial begin
    int k, base, seen_low;
    int t_rst, t_clk, t_pwr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    idle_outputs("R9");
    chk("R4 io_rx idle", io_rx, 1);

    foreach (VEC[i]) begin
      detect_invert = VEC[i][3];
      tick_per      = int'(VEC[i][2:0]);
      card_detect   = VEC[i][3];
      repeat (SETTLE + 10) @(negedge clk);
      chk("R1 absent level keeps power off", pwr_en_n, 1);
      card_detect = ~VEC[i][3];
      wait_power(k);
      chk("R2 power delay", k, EXP_PWR);
      chk("R3 clock starts with power", card_clk_en, 1);
      chk("R4 io_rx during activation", io_rx, 1);
      chk("R5 reset low at power-up", card_rst_n, 0);
      base = ticks_seen;
      k = 0;
      while (!card_rst_n && k < 5000) begin @(negedge clk); k++; end
      chk("R5 ticks before reset release", ticks_seen - base, RSTCLK);
      chk("R6 ready with reset released", ready, 1);
      card_detect = VEC[i][3];
      t_rst = 0; t_clk = 0; t_pwr = 0;
      for (int c = 1; c <= 8; c++) begin
        @(negedge clk);
        if (!card_rst_n && t_rst == 0) begin
          t_rst = c;
          chk("R6 ready drops with reset", ready, 0);
        end
        if (!card_clk_en && t_clk == 0) t_clk = c;
        if (pwr_en_n && t_pwr == 0) t_pwr = c;
      end
      chk("R7 reset drop cycle", t_rst, 3);
      chk("R7 clock stop cycle", t_clk, 4);
      chk("R7 power off cycle", t_pwr, 5);
    end

    // R8: removal during settling delay
    detect_invert = 0; tick_per = 1;
    card_detect = 1;
    repeat (10) @(negedge clk);
    card_detect = 0;
    seen_low = 0;
    repeat (SETTLE + 10) begin
      @(negedge clk);
      if (!pwr_en_n) seen_low = 1;
    end
    chk("R8 no power after removal in settle", seen_low, 0);
    idle_outputs("R8 idle after settle removal");

    // R8: removal while reset still low
    card_detect = 1;
    wait_power(k);
    chk("R2 power delay second pass", k, EXP_PWR);
    repeat (20) @(negedge clk);
    card_detect = 0;
    t_clk = 0; t_pwr = 0; seen_low = 0;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      if (card_rst_n) seen_low = 1;
      if (!card_clk_en && t_clk == 0) t_clk = c;
      if (pwr_en_n && t_pwr == 0) t_pwr = c;
    end
    chk("R8 clock stop cycle early removal", t_clk, 3);
    chk("R8 power off cycle early removal", t_pwr, 4);
    chk("R8 reset never released", seen_low, 0);

    // R1: inverted sense, pin low means present
    detect_invert = 1; card_detect = 1;
    repeat (SETTLE + 10) @(negedge clk);
    chk("R1 inverted absent", pwr_en_n, 1);
    card_detect = 0;
    wait_power(k);
    chk("R1 inverted present powers slot", k, EXP_PWR);
    card_detect = 1;
    repeat (8) @(negedge clk);
    idle_outputs("R9 idle after shutdown");

    finish_run();
  end
endmodule